// File: doc/BRIEF.md
# Skewed-Slice Pipelined Ripple Adder

This block adds two unsigned WIDTH-bit words by cutting the ripple-carry chain into STAGES = WIDTH/SLICE stages of SLICE bits each. Only the carry between neighbouring stages is held in a register, so each stage's combinational path is SLICE full-adder cells deep. A new operand pair may enter on every clock.

In the default staggered mode (DESKEW = 0), slice s of an addition's operands is presented s clocks after slice 0, and slice s of the sum comes out s clocks after sum slice 0. Logic downstream has to expect the same stagger. Each slice carries its own valid bit. With DESKEW = 1, input delay lines take in a pair that is presented all at once, and output delay lines line the sum back up. Latency is then STAGES clocks.

Top module: `skad_adder`

## Requirements
- R1: For an addition whose slices are all valid, {cout_o, sum_o} reassembled across its slices equals a + b as an unsigned (WIDTH+1)-bit value. Slice s occupies bits [s*SLICE +: SLICE] of a_i, b_i and sum_o.
- R2: With DESKEW = 0, stage s takes slice s of the operands, with vld_i[s], on the clock edge s cycles after the edge that takes slice 0 of the same addition.
- R3: With DESKEW = 0, sum slice s and vld_o[s] hold the result of the slice taken at an edge from just after that edge until the next edge. Sum slice s of an addition is therefore visible s cycles after sum slice 0.
- R4: A new addition may start on every clock, and back-to-back additions do not disturb each other's results.
- R5: The carry leaving stage s reaches stage s+1 one clock later, and only if vld_i[s] was high. A slice taken with its valid low passes a carry of 0 onward, and its output sum slice reads 0.
- R6: While rst is high at a rising edge, the next outputs are vld_o = 0, sum_o = 0 and cout_o = 0. The carry and delay registers are cleared as well.
- R7: cout_o is the carry out of the top slice. It is valid in the same cycle as vld_o[STAGES-1] and reads 0 whenever vld_o[STAGES-1] is low.
- R8: With DESKEW = 1, every slice of an operand pair is presented in the same cycle, with every vld_i bit set to the pair's valid. After the STAGES-th rising edge, counting the edge that takes the pair, all of sum_o, cout_o and vld_o show its result together.
- R9: With DESKEW = 0, vld_o[s] equals the vld_i[s] taken at the preceding edge. Slices travel independently, so a mix of valid and idle slices is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | WIDTH/SLICE | Per-slice operand valid |
| a_i | input | WIDTH | Operand A, slices staggered when DESKEW = 0 |
| b_i | input | WIDTH | Operand B, slices staggered when DESKEW = 0 |
| sum_o | output | WIDTH | Sum slices, staggered when DESKEW = 0 |
| vld_o | output | WIDTH/SLICE | Per-slice sum valid |
| cout_o | output | 1 | Carry out of the top slice |

## Verification
The bench builds two instances. The first uses WIDTH = 8, SLICE = 2 and DESKEW = 0: four staggered stages, which make the carry ripple across three stage registers and let per-slice valid masks show that an idle slice blocks the carry. The second uses WIDTH = 12, SLICE = 3 and DESKEW = 1, which brings the input and output delay lines, odd slice widths and the STAGES-clock alignment within reach. Both are fed back-to-back seeded random pairs mixed with directed all-ones carry chains and idle gaps.

// File: rtl/skad_pkg.sv
package skad_pkg;

    // one full-adder cell: returns {carry, sum}
    function automatic logic [1:0] fa_cell(input logic x, input logic y, input logic ci);
        logic cy;
        logic sm;
        cy = (x & y) | (x & ci) | (y & ci);
        sm = x ^ y ^ ci;
        return {cy, sm};
    endfunction

endpackage

// File: rtl/skad_dly.sv
module skad_dly #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_line
            logic [DEPTH-1:0][W-1:0] line_d;
            logic [DEPTH-1:0][W-1:0] line_q;

            always_comb begin
                line_d[0] = d_i;
                for (int i = 1; i < DEPTH; i++) begin
                    line_d[i] = line_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) line_q <= '0;
                else     line_q <= line_d;
            end

            assign q_o = line_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/skad_stage.sv
module skad_stage
    import skad_pkg::*;
#(
    parameter int SLICE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [SLICE-1:0] a_i,
    input  logic [SLICE-1:0] b_i,
    input  logic             cin_i,
    output logic [SLICE-1:0] sum_o,
    output logic             vld_o,
    output logic             cout_o
);
    typedef struct packed {
        logic [SLICE-1:0] sum;
        logic             vld;
        logic             cout;
    } stage_t;

    stage_t st_d, st_q;
    logic [SLICE-1:0] part_sum;
    logic             chain;

    always_comb begin
        chain    = cin_i;
        part_sum = '0;
        for (int i = 0; i < SLICE; i++) begin
            {chain, part_sum[i]} = fa_cell(a_i[i], b_i[i], chain);
        end
        st_d.vld  = vld_i;
        st_d.sum  = vld_i ? part_sum : '0;
        st_d.cout = vld_i & chain;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sum_o  = st_q.sum;
    assign vld_o  = st_q.vld;
    assign cout_o = st_q.cout;

    AST_SLICE_ADD: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> {cout_o, sum_o} == $past({1'b0, a_i} + {1'b0, b_i} + {{SLICE{1'b0}}, cin_i}))
        else $error("slice sum mismatch"); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (!vld_o && !cout_o && sum_o == '0))
        else $error("idle slice not quiet"); // R5
endmodule

// File: rtl/skad_adder.sv
module skad_adder #(
    parameter int WIDTH  = 4,
    parameter int SLICE  = 2,
    parameter bit DESKEW = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIDTH/SLICE-1:0] vld_i,
    input  logic [WIDTH-1:0]       a_i,
    input  logic [WIDTH-1:0]       b_i,
    output logic [WIDTH-1:0]       sum_o,
    output logic [WIDTH/SLICE-1:0] vld_o,
    output logic                   cout_o
);
    localparam int STAGES = WIDTH / SLICE;
    localparam int IN_W   = 2 * SLICE + 1;
    localparam int OUT_W  = SLICE + 1;

    logic [STAGES-1:0] carry_w;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_slice
            logic [IN_W-1:0]  in_raw, in_al;
            logic [OUT_W-1:0] out_raw, out_al;
            logic [SLICE-1:0] st_sum;
            logic             st_vld;
            logic             cin_w;

            assign in_raw = {vld_i[s], a_i[s*SLICE +: SLICE], b_i[s*SLICE +: SLICE]};

            skad_dly #(.W(IN_W), .DEPTH(DESKEW ? s : 0)) u_in_dly (
                .clk (clk),
                .rst (rst),
                .d_i (in_raw),
                .q_o (in_al)
            );

            if (s == 0) begin : g_cin0
                assign cin_w = 1'b0;
            end else begin : g_cinn
                assign cin_w = carry_w[s-1];
            end

            skad_stage #(.SLICE(SLICE)) u_stage (
                .clk    (clk),
                .rst    (rst),
                .vld_i  (in_al[IN_W-1]),
                .a_i    (in_al[2*SLICE-1:SLICE]),
                .b_i    (in_al[SLICE-1:0]),
                .cin_i  (cin_w),
                .sum_o  (st_sum),
                .vld_o  (st_vld),
                .cout_o (carry_w[s])
            );

            assign out_raw = {st_vld, st_sum};

            skad_dly #(.W(OUT_W), .DEPTH(DESKEW ? (STAGES - 1 - s) : 0)) u_out_dly (
                .clk (clk),
                .rst (rst),
                .d_i (out_raw),
                .q_o (out_al)
            );

            assign sum_o[s*SLICE +: SLICE] = out_al[SLICE-1:0];
            assign vld_o[s]                = out_al[SLICE];
        end
    endgenerate

    assign cout_o = carry_w[STAGES-1];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (vld_o == '0 && sum_o == '0 && !cout_o))
        else $error("outputs not cleared by reset"); // R6

    AST_COUT_GATED: assert property (@(posedge clk) disable iff (rst)
        !vld_o[STAGES-1] |-> !cout_o)
        else $error("carry out without top slice valid"); // R7
endmodule

// File: tb/skad_adder_test.sv
`timescale 1ns/1ps
module skad_adder_test;
    localparam int W1 = 8,  SL1 = 2, ST1 = W1 / SL1;
    localparam int W2 = 12, SL2 = 3, ST2 = W2 / SL2;
    localparam int NOPS = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [ST1-1:0] vi1, vo1;
    logic [W1-1:0]  a1, b1, s1;
    logic           c1;
    logic [ST2-1:0] vi2, vo2;
    logic [W2-1:0]  a2, b2, s2;
    logic           c2;

    skad_adder #(.WIDTH(W1), .SLICE(SL1), .DESKEW(1'b0)) uut (
        .clk(clk), .rst(rst), .vld_i(vi1), .a_i(a1), .b_i(b1),
        .sum_o(s1), .vld_o(vo1), .cout_o(c1));

    skad_adder #(.WIDTH(W2), .SLICE(SL2), .DESKEW(1'b1)) uut_al (
        .clk(clk), .rst(rst), .vld_i(vi2), .a_i(a2), .b_i(b2),
        .sum_o(s2), .vld_o(vo2), .cout_o(c2));

    logic [W1-1:0]  oa1 [NOPS];
    logic [W1-1:0]  ob1 [NOPS];
    logic [ST1-1:0] ov1 [NOPS];
    logic [W2-1:0]  oa2 [NOPS];
    logic [W2-1:0]  ob2 [NOPS];
    logic           ov2 [NOPS];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected staggered result of op j: {cout, sum} with idle slices zero
    function automatic logic [W1:0] exp1(input int j);
        logic [W1-1:0] sm;
        logic          cy;
        logic [SL1:0]  t;
        sm = '0;
        cy = 1'b0;
        for (int s = 0; s < ST1; s++) begin
            t = {1'b0, oa1[j][s*SL1 +: SL1]} + {1'b0, ob1[j][s*SL1 +: SL1]} + {{SL1{1'b0}}, cy};
            if (ov1[j][s]) begin
                sm[s*SL1 +: SL1] = t[SL1-1:0];
                cy = t[SL1];
            end else begin
                cy = 1'b0;
            end
        end
        return {cy, sm};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic drive(input int k);
        for (int s = 0; s < ST1; s++) begin
            int j;
            j = k - s;  // R2: slice s lags slice 0 by s cycles
            if (j >= 0 && j < NOPS) begin
                vi1[s]              = ov1[j][s];
                a1[s*SL1 +: SL1]    = oa1[j][s*SL1 +: SL1];
                b1[s*SL1 +: SL1]    = ob1[j][s*SL1 +: SL1];
            end else begin
                vi1[s]              = 1'b0;
                a1[s*SL1 +: SL1]    = SL1'($urandom);
                b1[s*SL1 +: SL1]    = SL1'($urandom);
            end
        end
        if (k < NOPS) begin
            vi2 = {ST2{ov2[k]}};
            a2  = oa2[k];
            b2  = ob2[k];
        end else begin
            vi2 = '0;
            a2  = W2'($urandom);
            b2  = W2'($urandom);
        end
    endtask

    task automatic check_cycle(input int k);
        logic [W1:0]   e1;
        logic [W2:0]   e2;
        int            j;
        // staggered instance: slice s shows op k-s (R3, R4, R9)
        for (int s = 0; s < ST1; s++) begin
            j = k - s;
            if (j >= 0 && j < NOPS) begin
                e1 = exp1(j);
                chk(vo1[s] == ov1[j][s], "R9 slice valid", 32'(vo1[s]), 32'(ov1[j][s]));
                chk(s1[s*SL1 +: SL1] == e1[s*SL1 +: SL1], "R1 R3 R5 sum slice",
                    32'(s1[s*SL1 +: SL1]), 32'(e1[s*SL1 +: SL1]));
                if (s == ST1 - 1)
                    chk(c1 == e1[W1], "R7 carry out", 32'(c1), 32'(e1[W1]));
            end else begin
                chk(vo1[s] == 1'b0 && s1[s*SL1 +: SL1] == '0, "R4 R9 idle slice",
                    32'(vo1[s]), 32'h0);
            end
        end
        // aligned instance: result of op k-(ST2-1) (R8)
        j = k - (ST2 - 1);
        if (j >= 0 && j < NOPS) begin
            e2 = ov2[j] ? ({1'b0, oa2[j]} + {1'b0, ob2[j]}) : '0;
            chk(vo2 == {ST2{ov2[j]}}, "R8 aligned valid", 32'(vo2), 32'({ST2{ov2[j]}}));
            chk({c2, s2} == e2, "R8 R1 aligned sum", 32'({c2, s2}), 32'(e2));
        end else begin
            chk(vo2 == '0 && c2 == 1'b0, "R8 aligned idle", 32'(vo2), 32'h0);
        end
    endtask

    initial begin
        void'($urandom(32'd20250110));
        // directed corner cases
        oa1[0] = 8'hFF; ob1[0] = 8'h01; ov1[0] = 4'hF;   // full carry chain
        oa1[1] = 8'hFF; ob1[1] = 8'hFF; ov1[1] = 4'hF;   // max + max
        oa1[2] = 8'h00; ob1[2] = 8'h00; ov1[2] = 4'hF;
        oa1[3] = 8'hFF; ob1[3] = 8'h01; ov1[3] = 4'b1011; // R5: idle slice 2 blocks carry
        oa1[4] = 8'hFF; ob1[4] = 8'hFF; ov1[4] = 4'h0;
        oa2[0] = 12'hFFF; ob2[0] = 12'h001; ov2[0] = 1'b1;
        oa2[1] = 12'hFFF; ob2[1] = 12'hFFF; ov2[1] = 1'b1;
        oa2[2] = 12'h000; ob2[2] = 12'h000; ov2[2] = 1'b1;
        oa2[3] = 12'hFFF; ob2[3] = 12'hFFF; ov2[3] = 1'b0;
        oa2[4] = 12'h800; ob2[4] = 12'h800; ov2[4] = 1'b1;
        for (int i = 5; i < NOPS; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            oa1[i] = W1'($urandom);
            ob1[i] = W1'($urandom);
            ov1[i] = (r < 10) ? ST1'($urandom) : ((r < 25) ? '0 : '1);
            oa2[i] = W2'($urandom);
            ob2[i] = W2'($urandom);
            ov2[i] = ($urandom_range(0, 99) < 85);
        end

        vi1 = '0; a1 = '0; b1 = '0;
        vi2 = '0; a2 = '0; b2 = '0;
        repeat (3) @(negedge clk);
        // R6: reset state
        chk(vo1 == '0 && s1 == '0 && !c1, "R6 reset staggered", 32'({c1, vo1, s1}), 32'h0);
        chk(vo2 == '0 && s2 == '0 && !c2, "R6 reset aligned", 32'({c2, vo2, s2}), 32'h0);
        rst = 1'b0;

        for (int k = 0; k < NOPS + ST1 + ST2; k++) begin
            drive(k);
            @(posedge clk);
            @(negedge clk);
            check_cycle(k);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule